// File: doc/BRIEF.md
# Pin Interrupt Controller

This unit turns eight already-selected input pin levels into eight interrupt request lines. Each channel is programmed on its own to work in edge mode or level mode. In edge mode, rising and falling transitions are enabled separately, and each detected transition is held in a sticky detect bit until software clears it. In level mode, the channel raises its request for as long as the pin sits at a programmed polarity.

Software uses a small 32-bit register bus with a byte address, write data, a write strobe, a read strobe and combinational read data. Enables are never written directly. They are changed through write-one-to-set and write-one-to-clear alias registers, so two agents can mask and unmask channels without a read-modify-write. Masking a channel means clearing its rising enable, plus its falling enable when falling edges are in use. Unmasking sets the same bits again. Each pin passes through a two-flop synchroniser before any detection.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset every register reads zero, all channels are in edge mode, and every request output is low.
- R2: Channel i is bit i of every register. A write of 1 to bit i of the set alias at 0x08 (rising/level enable) or at 0x14 (falling enable) sets that enable. A write of 1 to bit i of the clear alias at 0x0C (rising) or at 0x18 (falling) clears it. Zero bits in these writes change nothing. Reads of 0x04, 0x08 and 0x0C return the rising enables, and reads of 0x10, 0x14 and 0x18 return the falling enables. Writes to 0x04 and 0x10 are ignored.
- R3: In edge mode with its rising enable set, a channel latches a low-to-high pin transition into the rising detect bit, read at 0x1C. No rising edge is latched while the enable is clear.
- R4: In edge mode with its falling enable set, a channel latches a high-to-low pin transition into the falling detect bit, read at 0x20. No falling edge is latched while the enable is clear.
- R5: A write of 1 to a bit of 0x1C or 0x20 clears that detect bit. A write of 1 to a bit of the status register at 0x24 clears both detect bits of that channel. If an enabled edge arrives in the same cycle as the clear, the edge is kept.
- R6: In level mode the status bit equals rising enable AND (synchronised pin == falling enable), so a falling-enable bit of 1 means active-high and 0 means active-low. No detect bit is latched in level mode, and writes to 0x24 do not change a level-mode request.
- R7: The mode register at 0x00 is read/write. Bit i = 1 puts channel i in level mode and 0 puts it in edge mode.
- R8: Reads of any word offset above 0x24 return zero, and writes to them change no state. Data bits above bit 7 read as zero everywhere.
- R9: Each request output equals the channel's status bit, read at 0x24. In edge mode the status bit is the OR of the two detect bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; read data is zero when low |
| addr | input | 8 | Byte address; bits 1:0 ignored |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data |
| pin_in | input | 8 | Selected pin levels, asynchronous |
| irq | output | 8 | Interrupt requests, one per channel |

## Verification
A register write takes effect at the clock edge that samples it, and read data is valid in the same cycle as the read strobe. A pin change reaches a level-mode request after two clock edges and an edge-mode request after three: two synchroniser stages plus the detect latch. The reference model in the bench keeps a three-deep history of sampled pin values and updates its state at every rising edge. The request lines and any read data are compared at the following falling edge, so each result is checked exactly in the cycle it falls due and never by polling.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
   // word indices of the register map (byte offset / 4)
   localparam int REG_MODE    = 0;
   localparam int REG_REN     = 1;
   localparam int REG_REN_SET = 2;
   localparam int REG_REN_CLR = 3;
   localparam int REG_FEN     = 4;
   localparam int REG_FEN_SET = 5;
   localparam int REG_FEN_CLR = 6;
   localparam int REG_RDET    = 7;
   localparam int REG_FDET    = 8;
   localparam int REG_STAT    = 9;
   localparam int NUM_REGS    = 10;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
   parameter int NUM_CH = 8,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pin_in,
   output logic [NUM_CH-1:0] lvl,
   output logic [NUM_CH-1:0] rise,
   output logic [NUM_CH-1:0] fall
);
   logic [STAGES-1:0][NUM_CH-1:0] stg;
   logic [NUM_CH-1:0]             prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg  <= '0;
         prev <= '0;
      end else begin
         stg  <= {stg[STAGES-2:0], pin_in};
         prev <= stg[STAGES-1];
      end
   end

   assign lvl  = stg[STAGES-1];
   assign rise = lvl & ~prev;
   assign fall = prev & ~lvl;
endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_we,
   input  logic mode_d,
   input  logic ren_set,
   input  logic ren_clr,
   input  logic fen_set,
   input  logic fen_clr,
   input  logic rdet_clr,
   input  logic fdet_clr,
   input  logic lvl,
   input  logic rise,
   input  logic fall,
   output logic mode,
   output logic ren,
   output logic fen,
   output logic rdet,
   output logic fdet,
   output logic stat
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= 1'b0;
         ren  <= 1'b0;
         fen  <= 1'b0;
         rdet <= 1'b0;
         fdet <= 1'b0;
      end else begin
         if (mode_we) mode <= mode_d;
         ren  <= (ren | ren_set) & ~ren_clr;
         fen  <= (fen | fen_set) & ~fen_clr;
         // a new edge wins over a clear in the same cycle
         rdet <= (rdet & ~rdet_clr) | (rise & ren & ~mode);
         fdet <= (fdet & ~fdet_clr) | (fall & fen & ~mode);
      end
   end

   assign stat = mode ? (ren & (lvl == fen)) : (rdet | fdet);
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
   import pin_irq_pkg::*;
#(
   parameter int NUM_CH      = 8,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data,
   input  logic [NUM_CH-1:0] pin_in,
   output logic [NUM_CH-1:0] irq
);
   localparam int IDX_W = ADDR_W - 2;

   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
      $error("NUM_CH must lie between 1 and DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (IDX_W < 4) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [IDX_W-1:0]    widx;
   logic [NUM_REGS-1:0] hit;
   logic [NUM_CH-1:0]   wmask;
   logic [NUM_CH-1:0]   lvl, rise, fall;
   logic [NUM_CH-1:0]   mode, ren, fen, rdet, fdet, stat;

   assign widx  = addr[ADDR_W-1:2];
   assign wmask = wr_en ? wdata[NUM_CH-1:0] : '0;

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_dec
      assign hit[k] = (widx == IDX_W'(k));
   end

   pin_irq_sync #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
      .lvl(lvl), .rise(rise), .fall(fall)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      pin_irq_chan i_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .mode_we  (wr_en & hit[REG_MODE]),
         .mode_d   (wdata[i]),
         .ren_set  (wmask[i] & hit[REG_REN_SET]),
         .ren_clr  (wmask[i] & hit[REG_REN_CLR]),
         .fen_set  (wmask[i] & hit[REG_FEN_SET]),
         .fen_clr  (wmask[i] & hit[REG_FEN_CLR]),
         .rdet_clr (wmask[i] & (hit[REG_RDET] | hit[REG_STAT])),
         .fdet_clr (wmask[i] & (hit[REG_FDET] | hit[REG_STAT])),
         .lvl      (lvl[i]),
         .rise     (rise[i]),
         .fall     (fall[i]),
         .mode     (mode[i]),
         .ren      (ren[i]),
         .fen      (fen[i]),
         .rdet     (rdet[i]),
         .fdet     (fdet[i]),
         .stat     (stat[i])
      );
   end

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         if (hit[REG_MODE])
            rd_data[NUM_CH-1:0] = mode;
         if (hit[REG_REN] | hit[REG_REN_SET] | hit[REG_REN_CLR])
            rd_data[NUM_CH-1:0] = ren;
         if (hit[REG_FEN] | hit[REG_FEN_SET] | hit[REG_FEN_CLR])
            rd_data[NUM_CH-1:0] = fen;
         if (hit[REG_RDET])
            rd_data[NUM_CH-1:0] = rdet;
         if (hit[REG_FDET])
            rd_data[NUM_CH-1:0] = fdet;
         if (hit[REG_STAT])
            rd_data[NUM_CH-1:0] = stat;
      end
   end

   assign irq = stat;
endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk #(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rd_data,
   input logic [NUM_CH-1:0] irq,
   input logic [NUM_CH-1:0] mode,
   input logic [NUM_CH-1:0] ren,
   input logic [NUM_CH-1:0] fen,
   input logic [NUM_CH-1:0] rdet,
   input logic [NUM_CH-1:0] fdet
);
   localparam int IDX_W = ADDR_W - 2;
   logic [IDX_W-1:0] widx;
   assign widx = addr[ADDR_W-1:2];

   a_r1_quiet_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq == '0));

   a_r2_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && widx == IDX_W'(2)) |=>
         ((ren & $past(wdata[NUM_CH-1:0])) == $past(wdata[NUM_CH-1:0])));

   a_r2_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && widx == IDX_W'(6)) |=> ((fen & $past(wdata[NUM_CH-1:0])) == '0));

   a_r3_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ((rdet & ~$past(rdet) & ~($past(ren) & ~$past(mode))) == '0));

   a_r4_fall_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ((fdet & ~$past(fdet) & ~($past(fen) & ~$past(mode))) == '0));

   a_r6_level_never_latches: assert property (@(posedge clk) disable iff (!rst_n)
      (((rdet | fdet) & ~($past(rdet) | $past(fdet)) & $past(mode)) == '0));

   a_r8_undefined_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && widx > IDX_W'(9)) |-> (rd_data == '0));

   a_r9_irq_is_status: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && widx == IDX_W'(9)) |-> (rd_data[NUM_CH-1:0] == irq));
endmodule

bind pin_irq_unit pin_irq_chk #(
   .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .rd_data(rd_data), .irq(irq), .mode(mode), .ren(ren),
   .fen(fen), .rdet(rdet), .fdet(fdet)
);

// File: tb/test_pin_irq_unit.sv
module test_pin_irq_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [7:0]  pins = '0;
   logic [31:0] rd_data;
   logic [7:0]  irq;

   always #5 clk = ~clk;

   pin_irq_unit i_pin_irq_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rd_data(rd_data), .pin_in(pins), .irq(irq)
   );

   // behavioural reference model
   logic [7:0] m_mode = '0, m_ren = '0, m_fen = '0, m_rdet = '0, m_fdet = '0;
   logic [7:0] hist[$] = '{8'h00, 8'h00, 8'h00};
   int    vectors = 0;
   int    errors  = 0;
   bit    done    = 1'b0;
   string cur_req = "R1";

   always @(posedge clk) begin
      if (rst_n) begin
         logic [7:0] s2, pv, rs, fl, wm, nr, nf;
         int idx;
         s2  = hist[1];
         pv  = hist[2];
         rs  = s2 & ~pv;
         fl  = pv & ~s2;
         wm  = wr_en ? wdata[7:0] : 8'h00;
         idx = int'(addr) / 4;
         nr  = (m_rdet & ~((idx == 7 || idx == 9) ? wm : 8'h00)) | (rs & m_ren & ~m_mode);
         nf  = (m_fdet & ~((idx == 8 || idx == 9) ? wm : 8'h00)) | (fl & m_fen & ~m_mode);
         m_rdet = nr;
         m_fdet = nf;
         if (wr_en && idx == 0) m_mode = wdata[7:0];
         if (idx == 2) m_ren = m_ren | wm;
         if (idx == 3) m_ren = m_ren & ~wm;
         if (idx == 5) m_fen = m_fen | wm;
         if (idx == 6) m_fen = m_fen & ~wm;
         hist.push_front(pins);
         void'(hist.pop_back());
      end
   end

   function automatic logic [7:0] exp_stat();
      return (m_mode & m_ren & ~(hist[1] ^ m_fen)) | (~m_mode & (m_rdet | m_fdet));
   endfunction

   function automatic logic [31:0] exp_rd(int idx);
      case (idx)
         0:       return {24'h0, m_mode};
         1, 2, 3: return {24'h0, m_ren};
         4, 5, 6: return {24'h0, m_fen};
         7:       return {24'h0, m_rdet};
         8:       return {24'h0, m_fdet};
         9:       return {24'h0, exp_stat()};
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cur_req, "irq", {24'h0, irq}, {24'h0, exp_stat()});
         if (rd_en) begin
            int idx;
            idx = int'(addr) / 4;
            if (idx > 9)
               check("R8", "undefined read", rd_data, 32'h0);
            else
               check(cur_req, "read data", rd_data, exp_rd(idx));
            if (idx == 9)
               check("R9", "status vs irq", rd_data, {24'h0, irq});
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      tick(1);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [7:0] a);
      rd_en = 1'b1; addr = a;
      tick(1);
      rd_en = 1'b0;
   endtask

   task automatic rd_all();
      for (int k = 0; k < 10; k++) rd(8'(k * 4));
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      int seed;
      tick(5);
      rst_n = 1'b1;
      tick(1);
      // R1: reset state
      cur_req = "R1";
      rd_all();

      // R2: set/clear aliases, direct writes ignored
      cur_req = "R2";
      wr(8'h08, 32'hFFFF_FFA5);
      rd(8'h04); rd(8'h08); rd(8'h0C);
      wr(8'h0C, 32'h21);
      wr(8'h04, 32'hFF);
      wr(8'h14, 32'h0F);
      wr(8'h18, 32'h03);
      wr(8'h10, 32'hFF);
      rd_all();

      // R7: mode register read/write
      cur_req = "R7";
      wr(8'h00, 32'hF0);
      rd(8'h00);
      wr(8'h00, 32'h00);
      rd(8'h00);

      // R3: rising edges
      cur_req = "R3";
      wr(8'h0C, 32'hFF);
      wr(8'h18, 32'hFF);
      wr(8'h08, 32'h0F);
      pins = 8'hFF;
      tick(4);
      rd(8'h1C); rd(8'h24);

      // R5: detect clear paths
      cur_req = "R5";
      wr(8'h1C, 32'h03);
      rd(8'h1C);
      wr(8'h24, 32'h0C);
      rd(8'h24);

      // R4: falling edges
      cur_req = "R4";
      wr(8'h14, 32'hF0);
      pins = 8'h00;
      tick(4);
      rd(8'h20); rd(8'h1C);
      cur_req = "R5";
      wr(8'h24, 32'hFF);
      rd_all();
      // R5: clear colliding with edge arrival at every phase
      for (int d = 0; d < 4; d++) begin
         wr(8'h08, 32'hFF);
         wr(8'h14, 32'hFF);
         pins = ~pins;
         tick(d);
         wr(8'h24, 32'hFF);
         tick(3);
         rd(8'h1C); rd(8'h20);
      end

      // R6: level mode, both polarities
      cur_req = "R6";
      wr(8'h24, 32'hFF);
      wr(8'h00, 32'hFF);
      wr(8'h18, 32'hFF);
      wr(8'h14, 32'h55);
      wr(8'h08, 32'hFF);
      foreach (hist[j]) ;
      for (int p = 0; p < 4; p++) begin
         pins = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'h3C : 8'hA5;
         tick(3);
         rd(8'h24);
         wr(8'h24, 32'hFF);
         rd(8'h1C); rd(8'h20);
      end
      wr(8'h0C, 32'h0F);
      tick(1);
      rd(8'h24);

      // R8: undefined offsets
      cur_req = "R8";
      rd(8'h28); rd(8'h3C); rd(8'hFC);
      wr(8'h28, 32'hFF); wr(8'h30, 32'hFF); wr(8'hFC, 32'hFF);
      rd_all();

      // mixed random traffic; per-cycle model compare
      cur_req = "R9";
      seed = 32'h1234_5678;
      for (int n = 0; n < 3000; n++) begin
         int op;
         seed = seed * 1103515245 + 12345;
         op   = (seed >>> 16) & 32'h7;
         if (op < 2) begin
            pins = 8'((seed >>> 8) & 32'hFF);
            tick(1);
         end else if (op < 5) begin
            wr(8'((((seed >>> 4) & 32'hF) % 11) * 4), 32'((seed >>> 12) & 32'hFFFF));
         end else begin
            rd(8'((((seed >>> 4) & 32'hF) % 11) * 4));
         end
      end
      tick(2);
      finish_run();
   end
endmodule